// File: doc/BRIEF.md
# Port-Based Configuration Access Responder

This block answers the legacy two-port configuration access scheme used by host software to discover and program devices behind a bridge. Software first loads a 32-bit selector into an address port. That selector carries an enable flag and the bus, device, function and register fields. Software then reads or writes through a four-byte data window, using byte, word or dword accesses. The responder keeps a 64-dword configuration image for each device slot. It serves lane-aligned reads and writes against that image.

On top of plain storage, the block mimics the behaviour that enumeration software expects from base-address registers. When all ones are written to a base-address slot, the slot answers with a fixed 4 KiB size mask, or with zero if that slot does not exist. I/O-type slots always read back with their I/O indicator bit set. Writes to the expansion ROM register are thrown away. Per-slot base-address counts and I/O flags, and the number of populated devices, come in on static inputs. Every read answer appears one cycle after the request.

Top module: `cfgport_responder`

## Requirements
- R1: A write to the address port (0xCF8) stores all 32 bits of write data. A read of that port returns the stored value. After reset the value is zero.
- R2: While bit 31 of the address register is 0, a read of the data window returns 0xFFFFFFFF and a write to it changes nothing.
- R3: The address register fields are bus = bits 23:16, device = bits 15:11, function = bits 10:8 and dword index = bits 7:2. A data-window read returns 0xFFFFFFFF if the bus is nonzero, the function is nonzero, the device is greater than `dev_count`, or the device has no storage slot (device >= NDEV).
- R4: After reset every dword reads as zero, except three dwords of device 0: dword 0 = {DEVICE_ID, VENDOR_ID}, dword 2 = {CLASS_ID, SUBCLASS_ID, 16'h0}, and dword 11 = {SUBSYS_ID, SUBSYS_VENDOR}.
- R5: The size code `io_size` is 0 for a byte, 1 for a word and 2 or 3 for a dword. The port offset is the low two bits of the port in 0xCFC..0xCFF. A dword read returns the whole dword. A word read returns bits 15:0 at offset 0 and bits 31:16 at any other offset. A byte read returns the dword shifted right by 8 × offset. Unused upper bits are zero.
- R6: A byte or word write changes only the lanes starting at the port offset, filled from the low bytes of `io_wdata`. Lanes past byte 3 are dropped. A dword write replaces the whole dword.
- R7: A dword write of 0xFFFFFFFF to dword 4..9 (base-address slot index = dword − 4) stores 0xFFFFF000 if the index is below that device's base-address count, and 0 otherwise.
- R8: Any write that covers byte 0 of an implemented base-address slot flagged as I/O stores bit 0 as 1.
- R9: Writes to dword 12 (byte offset 0x30, expansion ROM base) are discarded.
- R10: `rd_valid` is high exactly in the cycle after a read of either port, with `rd_data` valid in that cycle. A write is visible to a read in the next cycle.
- R11: Writes decode only the device field. Bus and function values do not stop a write to a device that has a storage slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_valid | input | 1 | Port access request this cycle |
| io_write | input | 1 | 1 = write, 0 = read |
| io_port | input | 16 | Port number |
| io_size | input | 2 | 0 byte, 1 word, 2/3 dword |
| io_wdata | input | 32 | Write data, low-justified |
| dev_count | input | 5 | Highest device number that still reads as present |
| bar_count | input | NDEV*3 | Implemented base-address slots per device, 3 bits each |
| bar_is_io | input | NDEV*6 | I/O-type flag per base-address slot, 6 bits per device |
| rd_valid | output | 1 | Read answer valid |
| rd_data | output | 32 | Read answer |

## Verification
The most interesting case is a single write where the size-probe substitution and the I/O bit forcing act together. An all-ones dword written to an implemented I/O slot must come back as 0xFFFFF001, not as the plain mask and not as all ones. The bench provokes this on slot 0 of device 1, which is flagged as I/O. It then probes the memory-type slot 1 and the missing slot 2 of the same device, and reads each one back on the very next cycle. The scoreboard compares each answer with a value worked out by hand from R7 and R8.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_WIDE  = 2'd3
  } acc_size_e;

  function automatic logic is_dword(input acc_size_e s);
    return (s == SZ_DWORD) || (s == SZ_WIDE);
  endfunction
endpackage

// File: rtl/cfgp_addr_reg.sv
module cfgp_addr_reg #(
  parameter logic [15:0] ADDR_PORT = 16'hCF8,
  parameter logic [15:0] DATA_PORT = 16'hCFC
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        io_valid,
  input  logic        io_write,
  input  logic [15:0] io_port,
  input  logic [31:0] io_wdata,
  output logic        hit_addr,
  output logic        hit_data,
  output logic [31:0] addr_reg
);
  assign hit_addr = io_valid && (io_port == ADDR_PORT);
  assign hit_data = io_valid && (io_port[15:2] == DATA_PORT[15:2]);

  always_ff @(posedge clk) begin
    if (rst) addr_reg <= '0;
    else if (hit_addr && io_write) addr_reg <= io_wdata;
  end

  // R1
  addr_load_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_addr && io_write) |=> (addr_reg == $past(io_wdata)));
endmodule

// File: rtl/cfgp_wr_shape.sv
module cfgp_wr_shape
  import cfgp_pkg::*;
#(
  parameter int          NBAR     = 6,
  parameter int          DWW      = 6,
  parameter int          BAR_DW0  = 4,
  parameter int          ROM_DW   = 12,
  parameter logic [31:0] BAR_MASK = 32'hFFFFF000,
  localparam int         CNT_W    = $clog2(NBAR + 1)
) (
  input  logic             wr,
  input  acc_size_e        size,
  input  logic [1:0]       ofs,
  input  logic [DWW-1:0]   dword,
  input  logic [31:0]      wdata,
  input  logic [CNT_W-1:0] bar_cnt,
  input  logic [NBAR-1:0]  bar_io,
  output logic [3:0]       be,
  output logic [31:0]      wd
);
  logic             in_bar, impl, is_io;
  logic [DWW-1:0]   rel;
  logic [31:0]      shifted;

  assign rel     = dword - DWW'(BAR_DW0);
  assign in_bar  = (dword >= DWW'(BAR_DW0)) && (dword < DWW'(BAR_DW0 + NBAR));
  assign impl    = in_bar && ({{(32-DWW){1'b0}}, rel} < {{(32-CNT_W){1'b0}}, bar_cnt});
  assign shifted = wdata << {ofs, 3'b000};

  always_comb begin
    is_io = 1'b0;
    for (int i = 0; i < NBAR; i++)
      if (rel == DWW'(i)) is_io = bar_io[i];
    is_io = is_io && impl;
  end

  always_comb begin
    case (size)
      SZ_BYTE: begin be = 4'b0001 << ofs; wd = shifted; end
      SZ_WORD: begin be = 4'b0011 << ofs; wd = shifted; end
      default: begin be = 4'b1111;        wd = wdata;   end
    endcase
    if (is_dword(size) && in_bar && (wdata == 32'hFFFF_FFFF))
      wd = impl ? BAR_MASK : 32'h0;
    if (is_io && be[0])
      wd[0] = 1'b1;
    if (!wr || (dword == DWW'(ROM_DW)))
      be = 4'b0000;
  end
endmodule

// File: rtl/cfgp_cfg_store.sv
module cfgp_cfg_store #(
  parameter int          NDEV          = 4,
  parameter int          NDW           = 64,
  parameter int          ROM_DW        = 12,
  parameter logic [15:0] VENDOR_ID     = 16'h1B36,
  parameter logic [15:0] DEVICE_ID     = 16'h0008,
  parameter logic [7:0]  CLASS_ID      = 8'h06,
  parameter logic [7:0]  SUBCLASS_ID   = 8'h00,
  parameter logic [15:0] SUBSYS_VENDOR = 16'h1B36,
  parameter logic [15:0] SUBSYS_ID     = 16'h0000,
  localparam int         DEVW          = $clog2(NDEV),
  localparam int         DWW           = $clog2(NDW),
  localparam int         NENT          = NDEV * NDW,
  localparam int         AW            = DEVW + DWW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DEVW-1:0] dev,
  input  logic [DWW-1:0]  dword,
  input  logic [3:0]      be,
  input  logic [31:0]     wd,
  output logic [31:0]     rd_word
);
  logic [31:0]     mem [NENT];
  logic [NENT-1:0] vld;
  logic [AW-1:0]   a;
  logic [31:0]     dflt, merged, q, dq;
  logic [3:0]      eff_be;
  logic            vq;

  assign a = {dev, dword};

  always_comb begin
    dflt = 32'h0;
    if (dev == '0) begin
      if (dword == DWW'(0))  dflt = {DEVICE_ID, VENDOR_ID};
      if (dword == DWW'(2))  dflt = {CLASS_ID, SUBCLASS_ID, 16'h0};
      if (dword == DWW'(11)) dflt = {SUBSYS_ID, SUBSYS_VENDOR};
    end
  end

  always_comb begin
    eff_be = (|be && !vld[a]) ? 4'hF : be;
    for (int i = 0; i < 4; i++)
      merged[8*i +: 8] = be[i] ? wd[8*i +: 8] : dflt[8*i +: 8];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < 4; i++)
      if (eff_be[i]) mem[a][8*i +: 8] <= vld[a] ? wd[8*i +: 8] : merged[8*i +: 8];
    q <= mem[a];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      vq  <= 1'b0;
      dq  <= '0;
    end else begin
      if (|be) vld[a] <= 1'b1;
      vq <= vld[a];
      dq <= dflt;
    end
  end

  assign rd_word = vq ? q : dq;

  // R9
  rom_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (|be) |-> (dword != DWW'(ROM_DW)));
endmodule

// File: rtl/cfgp_rd_lane.sv
module cfgp_rd_lane
  import cfgp_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        rd_req,
  input  logic        sel_addr,
  input  logic        force_ones,
  input  acc_size_e   size,
  input  logic [1:0]  ofs,
  input  logic [31:0] addr_reg,
  input  logic [31:0] word,
  output logic        rd_valid,
  output logic [31:0] rd_data
);
  logic        sel_q, ones_q;
  acc_size_e   size_q;
  logic [1:0]  ofs_q;
  logic [31:0] areg_q, sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      sel_q    <= 1'b0;
      ones_q   <= 1'b0;
      size_q   <= SZ_DWORD;
      ofs_q    <= '0;
      areg_q   <= '0;
    end else begin
      rd_valid <= rd_req;
      sel_q    <= sel_addr;
      ones_q   <= force_ones;
      size_q   <= size;
      ofs_q    <= ofs;
      areg_q   <= addr_reg;
    end
  end

  assign sh = word >> {ofs_q, 3'b000};

  always_comb begin
    if (sel_q)       rd_data = areg_q;
    else if (ones_q) rd_data = 32'hFFFF_FFFF;
    else begin
      case (size_q)
        SZ_BYTE: rd_data = {24'h0, sh[7:0]};
        SZ_WORD: rd_data = (ofs_q == 2'd0) ? {16'h0, word[15:0]} : {16'h0, word[31:16]};
        default: rd_data = word;
      endcase
    end
  end
endmodule

// File: rtl/cfgport_responder.sv
module cfgport_responder
  import cfgp_pkg::*;
#(
  parameter int          NDEV          = 4,
  parameter int          NBAR          = 6,
  parameter int          NDW           = 64,
  parameter logic [15:0] ADDR_PORT     = 16'hCF8,
  parameter logic [15:0] DATA_PORT     = 16'hCFC,
  parameter int          BAR_DW0       = 4,
  parameter int          ROM_DW        = 12,
  parameter logic [31:0] BAR_MASK      = 32'hFFFFF000,
  parameter logic [15:0] VENDOR_ID     = 16'h1B36,
  parameter logic [15:0] DEVICE_ID     = 16'h0008,
  parameter logic [7:0]  CLASS_ID      = 8'h06,
  parameter logic [7:0]  SUBCLASS_ID   = 8'h00,
  parameter logic [15:0] SUBSYS_VENDOR = 16'h1B36,
  parameter logic [15:0] SUBSYS_ID     = 16'h0000,
  localparam int         CNT_W         = $clog2(NBAR + 1),
  localparam int         DEVW          = $clog2(NDEV),
  localparam int         DWW           = $clog2(NDW)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  io_valid,
  input  logic                  io_write,
  input  logic [15:0]           io_port,
  input  logic [1:0]            io_size,
  input  logic [31:0]           io_wdata,
  input  logic [4:0]            dev_count,
  input  logic [NDEV*CNT_W-1:0] bar_count,
  input  logic [NDEV*NBAR-1:0]  bar_is_io,
  output logic                  rd_valid,
  output logic [31:0]           rd_data
);
  logic            hit_addr, hit_data, rd_req, dev_ok, wr, force_ones;
  logic [31:0]     addr_reg;
  logic [7:0]      f_bus;
  logic [4:0]      f_dev;
  logic [2:0]      f_fn;
  logic [DWW-1:0]  f_dw;
  logic [DEVW-1:0] dev_idx;
  logic [1:0]      ofs;
  logic [3:0]      be;
  logic [31:0]     wd, word;
  acc_size_e       size;

  cfgp_addr_reg #(.ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)) u_areg (
    .clk(clk), .rst(rst), .io_valid(io_valid), .io_write(io_write),
    .io_port(io_port), .io_wdata(io_wdata),
    .hit_addr(hit_addr), .hit_data(hit_data), .addr_reg(addr_reg));

  assign f_bus   = addr_reg[23:16];
  assign f_dev   = addr_reg[15:11];
  assign f_fn    = addr_reg[10:8];
  assign f_dw    = addr_reg[2 +: DWW];
  assign dev_idx = f_dev[DEVW-1:0];
  assign ofs     = io_port[1:0];
  assign size    = acc_size_e'(io_size);
  assign dev_ok  = ({27'h0, f_dev} < NDEV);
  assign rd_req  = (hit_addr || hit_data) && !io_write;
  assign wr      = hit_data && io_write && addr_reg[31] && dev_ok;
  assign force_ones = hit_data && (!addr_reg[31] || (f_bus != 8'h0) ||
                      (f_fn != 3'h0) || (f_dev > dev_count) || !dev_ok);

  cfgp_wr_shape #(.NBAR(NBAR), .DWW(DWW), .BAR_DW0(BAR_DW0), .ROM_DW(ROM_DW),
                  .BAR_MASK(BAR_MASK)) u_shape (
    .wr(wr), .size(size), .ofs(ofs), .dword(f_dw), .wdata(io_wdata),
    .bar_cnt(bar_count[dev_idx*CNT_W +: CNT_W]),
    .bar_io(bar_is_io[dev_idx*NBAR +: NBAR]),
    .be(be), .wd(wd));

  cfgp_cfg_store #(.NDEV(NDEV), .NDW(NDW), .ROM_DW(ROM_DW),
                   .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID),
                   .CLASS_ID(CLASS_ID), .SUBCLASS_ID(SUBCLASS_ID),
                   .SUBSYS_VENDOR(SUBSYS_VENDOR), .SUBSYS_ID(SUBSYS_ID)) u_store (
    .clk(clk), .rst(rst), .dev(dev_idx), .dword(f_dw), .be(be), .wd(wd),
    .rd_word(word));

  cfgp_rd_lane u_lane (
    .clk(clk), .rst(rst), .rd_req(rd_req), .sel_addr(hit_addr),
    .force_ones(force_ones), .size(size), .ofs(ofs), .addr_reg(addr_reg),
    .word(word), .rd_valid(rd_valid), .rd_data(rd_data));

  // R10
  rd_timing_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid);

  // R10
  rd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rd_valid);

  // R2
  dis_read_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_data && !io_write && !addr_reg[31]) |=> (rd_data == 32'hFFFF_FFFF));

  // R1
  addr_echo_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_addr && !io_write) |=> (rd_data == $past(addr_reg)));
endmodule

// File: tb/cfgport_responder_tb.sv
module cfgport_responder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_valid = 1'b0, io_write = 1'b0;
  logic [15:0] io_port = '0;
  logic [1:0]  io_size = '0;
  logic [31:0] io_wdata = '0;
  logic [4:0]  dev_count = 5'd3;
  logic [11:0] bar_count = {3'd0, 3'd0, 3'd2, 3'd0};
  logic [23:0] bar_is_io = 24'h000040;
  logic        rd_valid;
  logic [31:0] rd_data;

  int checks = 0, failures = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  cfgport_responder u_dut (
    .clk(clk), .rst(rst), .io_valid(io_valid), .io_write(io_write),
    .io_port(io_port), .io_size(io_size), .io_wdata(io_wdata),
    .dev_count(dev_count), .bar_count(bar_count), .bar_is_io(bar_is_io),
    .rd_valid(rd_valid), .rd_data(rd_data));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [15:0] p, input logic [1:0] s, input logic [31:0] d);
    io_valid = 1'b1; io_write = w; io_port = p; io_size = s; io_wdata = d;
    @(negedge clk);
    io_valid = 1'b0; io_write = 1'b0;
  endtask

  task automatic rd(input logic [15:0] p, input logic [1:0] s, input logic [31:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    acc(1'b0, p, s, 32'h0);
  endtask

  task automatic sel(input logic [31:0] a);
    acc(1'b1, 16'hCF8, 2'd2, a);
  endtask

  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) check("R10 unexpected rd_valid", 32'h1, 32'h0);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog: actual running expected done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R10 reset rd_valid", {31'h0, rd_valid}, 32'h0);
    rd(16'hCF8, 2'd2, 32'h0, "R1 reset address");
    sel(32'h8000_0840);
    rd(16'hCF8, 2'd2, 32'h8000_0840, "R1 readback");
    // R2: disabled window
    sel(32'h0000_0000);
    rd(16'hCFC, 2'd2, 32'hFFFF_FFFF, "R2 read disabled");
    acc(1'b1, 16'hCFC, 2'd2, 32'h1234_5678);
    sel(32'h8000_0000);
    rd(16'hCFC, 2'd2, 32'h0008_1B36, "R2 write ignored / R4 id");
    // R4
    sel(32'h8000_0008);
    rd(16'hCFC, 2'd2, 32'h0600_0000, "R4 class");
    sel(32'h8000_002C);
    rd(16'hCFC, 2'd2, 32'h0000_1B36, "R4 subsys");
    sel(32'h8000_0004);
    rd(16'hCFC, 2'd2, 32'h0, "R4 zero dev0");
    sel(32'h8000_1800);
    rd(16'hCFC, 2'd2, 32'h0, "R4 zero dev3 / R3 dev==count");
    // R10 back-to-back write then read
    sel(32'h8000_0840);
    acc(1'b1, 16'hCFC, 2'd2, 32'hDEAD_BEEF);
    rd(16'hCFC, 2'd2, 32'hDEAD_BEEF, "R10 write then read");
    // R5 lanes
    rd(16'hCFD, 2'd0, 32'h0000_00BE, "R5 byte ofs1");
    rd(16'hCFF, 2'd0, 32'h0000_00DE, "R5 byte ofs3");
    rd(16'hCFC, 2'd1, 32'h0000_BEEF, "R5 word ofs0");
    rd(16'hCFE, 2'd1, 32'h0000_DEAD, "R5 word ofs2");
    rd(16'hCFD, 2'd1, 32'h0000_DEAD, "R5 word ofs1");
    rd(16'hCFF, 2'd3, 32'hDEAD_BEEF, "R5 dword code3");
    // R6 narrow writes
    acc(1'b1, 16'hCFE, 2'd0, 32'hFFFF_FFA5);
    rd(16'hCFC, 2'd2, 32'hDEA5_BEEF, "R6 byte write");
    acc(1'b1, 16'hCFD, 2'd1, 32'h0000_1234);
    rd(16'hCFC, 2'd2, 32'hDE12_34EF, "R6 word write");
    sel(32'h8000_1044);
    acc(1'b1, 16'hCFD, 2'd0, 32'h0000_0077);
    rd(16'hCFC, 2'd2, 32'h0000_7700, "R6 byte into fresh dword");
    // R7 + R8 sizing probes
    sel(32'h8000_0810);
    acc(1'b1, 16'hCFC, 2'd2, 32'hFFFF_FFFF);
    rd(16'hCFC, 2'd2, 32'hFFFF_F001, "R7 R8 io probe");
    sel(32'h8000_0814);
    acc(1'b1, 16'hCFC, 2'd2, 32'hFFFF_FFFF);
    rd(16'hCFC, 2'd2, 32'hFFFF_F000, "R7 mem probe");
    sel(32'h8000_0818);
    acc(1'b1, 16'hCFC, 2'd2, 32'hFFFF_FFFF);
    rd(16'hCFC, 2'd2, 32'h0, "R7 missing slot");
    acc(1'b1, 16'hCFC, 2'd2, 32'h0000_1234);
    rd(16'hCFC, 2'd2, 32'h0000_1234, "R8 missing slot plain");
    sel(32'h8000_0810);
    acc(1'b1, 16'hCFC, 2'd2, 32'h0000_C000);
    rd(16'hCFC, 2'd2, 32'h0000_C001, "R8 io bit");
    sel(32'h8000_0814);
    acc(1'b1, 16'hCFC, 2'd2, 32'hE000_0000);
    rd(16'hCFC, 2'd2, 32'hE000_0000, "R8 mem untouched");
    // R9
    sel(32'h8000_0830);
    acc(1'b1, 16'hCFC, 2'd2, 32'hCAFE_0000);
    rd(16'hCFC, 2'd2, 32'h0, "R9 rom discard");
    // R3 out of range
    sel(32'h8001_0000);
    rd(16'hCFC, 2'd2, 32'hFFFF_FFFF, "R3 bus nonzero");
    sel(32'h8000_0100);
    rd(16'hCFC, 2'd2, 32'hFFFF_FFFF, "R3 function nonzero");
    sel(32'h8000_2000);
    rd(16'hCFC, 2'd2, 32'hFFFF_FFFF, "R3 device above count");
    // R11
    sel(32'h8000_0948);
    acc(1'b1, 16'hCFC, 2'd2, 32'h0BAD_F00D);
    sel(32'h8000_0848);
    rd(16'hCFC, 2'd2, 32'h0BAD_F00D, "R11 function ignored on write");
    repeat (3) @(negedge clk);
    check("R10 all answers arrived", exp_q.size(), 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule